// File: doc/BRIEF.md
# Multi-Policy Bus Arbiter

This block decides which of N processors (four by default) owns a single shared bus. Each processor has a request input and a grant output. The arbiter also drives a busy line that is high while any processor holds mastership. A new master is chosen only while the bus is free. The winner keeps its grant until it lowers its request. The grant then clears, and arbitration resumes on the edge after that.

A two-bit mode input selects the priority policy used to pick among simultaneous requesters. The policies are rotating priority, least-recently-used priority, and pseudo-random priority driven by a linear feedback shift register. All three sets of priority state advance on every grant, whichever policy picked the winner. This means that a change of mode between arbitrations has a defined outcome. While no processor requests the bus, nothing moves.

Top module: `bus_arbiter_mp`

## Requirements
- R1: At most one grant bit is high in any cycle, and a grant is issued only to a processor whose request was high in the cycle before the grant appeared.
- R2: While reset (synchronous, active high) is asserted and just after it, all grants and busy are low. The rotating pointer is 0, the usage list runs from processor 0 (least recent) to processor N-1, and the shift register holds its seed 0xA5.
- R3: Busy is high exactly when some grant is high. A grant stays unchanged for as long as its owner keeps its request high, whatever other processors request.
- R4: When the owner's request is low at a clock edge, the grant clears at that edge. No new grant appears before the following edge, so at least one cycle with busy low separates two masters.
- R5: If the bus is free and at least one request is high at an edge, a one-hot grant is issued at that same edge.
- R6: Mode 0 (and also mode 3) is rotating: the search for a requester starts at the pointer and moves upward with wraparound. The pointer advances by one, modulo N, after every grant.
- R7: Mode 1 is least-recently-used: the winner is the requester that appears earliest in the usage list. After every grant, the granted index is removed from the list and placed at its most-recent end.
- R8: Mode 2 is random: the search starts at the shift register value modulo N and moves upward with wraparound. The 8-bit register shifts left by one and takes as its new bit 0 the XOR of bits 7, 5, 4 and 3. It steps once per grant.
- R9: In a cycle where the bus is free and no request is high, no grant is issued and no priority state changes.
- R10: The pointer, usage list and shift register all update on every grant, regardless of the mode that picked the winner.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode | input | 2 | Policy: 0 rotating, 1 least recently used, 2 random, 3 rotating |
| req | input | N | Bus request, one bit per processor |
| gnt | output | N | Bus grant, one-hot or zero |
| busy | output | 1 | High while a master holds the bus |

## Verification
The bench sweeps every non-empty request pattern under every mode. It keeps its own model of the pointer, usage list and shift register. This exposes a pointer that rotates during idle cycles, a usage list that moves the wrong entry, or a register that steps with the wrong taps, because each of these leads to a different winner later in the run. One test releases the bus while other processors are still requesting. A design that hands over in the same edge would show a new grant with no busy-low cycle between masters. Hold checks keep other requests high while the owner is served. A design that re-arbitrates while busy would move the grant.

// File: rtl/arb_pkg.sv
package arb_pkg;

  typedef enum logic [1:0] {
    POL_ROTATE = 2'd0,
    POL_LRU    = 2'd1,
    POL_RANDOM = 2'd2,
    POL_ROTATE_ALT = 2'd3
  } arb_policy_e;

  // (a + b) mod n, used for wraparound searches and pointer steps
  function automatic int wrap_add(input int a, input int b, input int n);
    return (a + b) % n;
  endfunction

endpackage

// File: rtl/arb_scan.sv
// Finds the first set request bit at or above a start index, wrapping.
module arb_scan #(
  parameter int N  = 4,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  input  logic [IW-1:0] start,
  output logic [IW-1:0] idx,
  output logic          hit
);
  import arb_pkg::*;

  always_comb begin
    idx = '0;
    hit = 1'b0;
    for (int k = N - 1; k >= 0; k--) begin
      if (req[wrap_add(int'(start), k, N)]) begin
        idx = IW'(wrap_add(int'(start), k, N));
        hit = 1'b1;
      end
    end
  end
endmodule

// File: rtl/arb_lru.sv
// Usage list: entry 0 is least recently granted, entry N-1 most recent.
module arb_lru #(
  parameter int N  = 4,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  req,
  input  logic          upd,
  input  logic [IW-1:0] upd_idx,
  output logic [IW-1:0] pick_idx,
  output logic          pick_hit
);
  logic [IW-1:0] order_q [N];
  logic [IW-1:0] order_n [N];
  int            pos;

  always_comb begin
    pick_idx = '0;
    pick_hit = 1'b0;
    for (int k = N - 1; k >= 0; k--) begin
      if (req[order_q[k]]) begin
        pick_idx = order_q[k];
        pick_hit = 1'b1;
      end
    end
  end

  always_comb begin
    pos = N - 1;
    for (int k = N - 1; k >= 0; k--) begin
      if (order_q[k] == upd_idx) pos = k;
    end
    for (int k = 0; k < N - 1; k++) begin
      order_n[k] = (k >= pos) ? order_q[k + 1] : order_q[k];
    end
    order_n[N-1] = upd_idx;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < N; k++) order_q[k] <= IW'(k);
    end else if (upd) begin
      for (int k = 0; k < N; k++) order_q[k] <= order_n[k];
    end
  end
endmodule

// File: rtl/arb_lfsr.sv
module arb_lfsr #(
  parameter int           W    = 8,
  parameter logic [W-1:0] TAPS = 8'hB8,
  parameter logic [W-1:0] SEED = 8'hA5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step,
  output logic [W-1:0] value
);
  always_ff @(posedge clk) begin
    if (rst)       value <= SEED;
    else if (step) value <= {value[W-2:0], ^(value & TAPS)};
  end
endmodule

// File: rtl/bus_arbiter_mp.sv
module bus_arbiter_mp #(
  parameter int N      = 4,
  parameter int LFSR_W = 8,
  localparam int IW    = (N > 1) ? $clog2(N) : 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [1:0]   mode,
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt,
  output logic         busy
);
  import arb_pkg::*;

  logic [N-1:0]      gnt_q;
  logic [IW-1:0]     rot_ptr;
  logic [LFSR_W-1:0] lfsr_val;
  logic [IW-1:0]     scan_start;
  logic [IW-1:0]     scan_idx;
  logic              scan_hit;
  logic [IW-1:0]     lru_idx;
  logic              lru_hit;
  logic [IW-1:0]     win_idx;
  logic              grant_evt;
  logic              release_evt;
  arb_policy_e       policy;

  assign policy      = arb_policy_e'(mode);
  assign busy        = |gnt_q;
  assign gnt         = gnt_q;
  assign grant_evt   = !busy && (|req);
  assign release_evt = busy && ((gnt_q & req) == '0);

  assign scan_start = (policy == POL_RANDOM) ? IW'(int'(lfsr_val) % N) : rot_ptr;
  assign win_idx    = (policy == POL_LRU) ? lru_idx : scan_idx;

  arb_scan #(.N(N), .IW(IW)) scan_i (
    .req(req), .start(scan_start), .idx(scan_idx), .hit(scan_hit)
  );

  arb_lru #(.N(N), .IW(IW)) lru_i (
    .clk(clk), .rst(rst), .req(req), .upd(grant_evt), .upd_idx(win_idx),
    .pick_idx(lru_idx), .pick_hit(lru_hit)
  );

  arb_lfsr #(.W(LFSR_W)) lfsr_i (
    .clk(clk), .rst(rst), .step(grant_evt), .value(lfsr_val)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      gnt_q   <= '0;
      rot_ptr <= '0;
    end else begin
      if (grant_evt && (scan_hit || lru_hit)) begin
        gnt_q   <= N'(1) << win_idx;
        rot_ptr <= IW'(wrap_add(int'(rot_ptr), 1, N));
      end else if (release_evt) begin
        gnt_q <= '0;
      end
    end
  end
endmodule

// File: rtl/arb_chk.sv
module arb_chk #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input logic          clk,
  input logic          rst,
  input logic [N-1:0]  req,
  input logic [N-1:0]  gnt,
  input logic          busy,
  input logic          grant_evt,
  input logic [IW-1:0] rot_ptr
);
  AST_GNT_ONEHOT0: assert property (@(posedge clk) disable iff (rst) $onehot0(gnt)); // R1
  AST_GNT_TO_REQ: assert property (@(posedge clk) disable iff (rst)
    (!busy && req != '0) |=> ($onehot(gnt) && (gnt & $past(req)) != '0)); // R5
  AST_GNT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (busy && (gnt & req) != '0) |=> (gnt == $past(gnt))); // R3
  AST_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (busy && (gnt & req) == '0) |=> (gnt == '0)); // R4
  AST_BUSY_LINE: assert property (@(posedge clk) disable iff (rst)
    busy |-> (gnt != '0)); // R3
  AST_IDLE_NO_GRANT: assert property (@(posedge clk) disable iff (rst)
    (!busy && req == '0) |=> (gnt == '0)); // R9
  AST_PTR_STILL: assert property (@(posedge clk) disable iff (rst)
    !grant_evt |=> $stable(rot_ptr)); // R9
endmodule

bind bus_arbiter_mp arb_chk #(.N(N), .IW(IW)) chk_i (
  .clk(clk), .rst(rst), .req(req), .gnt(gnt), .busy(busy),
  .grant_evt(grant_evt), .rot_ptr(rot_ptr)
);

// File: tb/bus_arbiter_mp_tb.sv
`timescale 1ns/1ps
module bus_arbiter_mp_tb_top;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [1:0]   mode = 2'd0;
  logic [N-1:0] req = '0;
  logic [N-1:0] gnt;
  logic         busy;

  int n_checks = 0;
  int n_fail   = 0;

  int        m_ptr;
  int        m_order [N];
  logic [7:0] m_lfsr;

  always #2 clk = ~clk;

  bus_arbiter_mp #(.N(N)) dut_i (
    .clk(clk), .rst(rst), .mode(mode), .req(req), .gnt(gnt), .busy(busy)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic int model_pick(input int m, input logic [N-1:0] r);
    int s;
    if (m == 1) begin
      for (int k = 0; k < N; k++) if (r[m_order[k]]) return m_order[k];
      return -1;
    end
    s = (m == 2) ? (int'(m_lfsr) % N) : m_ptr;
    for (int k = 0; k < N; k++) if (r[(s + k) % N]) return (s + k) % N;
    return -1;
  endfunction

  task automatic model_update(input int w);
    int p;
    logic fb;
    m_ptr = (m_ptr + 1) % N;
    fb = m_lfsr[7] ^ m_lfsr[5] ^ m_lfsr[4] ^ m_lfsr[3];
    m_lfsr = {m_lfsr[6:0], fb};
    p = 0;
    for (int k = 0; k < N; k++) if (m_order[k] == w) p = k;
    for (int k = p; k < N - 1; k++) m_order[k] = m_order[k + 1];
    m_order[N-1] = w;
  endtask

  function automatic string pol_tag(input int m);
    if (m == 1) return "R7";
    if (m == 2) return "R8";
    return "R6";
  endfunction

  // one full arbitration: request, grant, hold, release, idle
  task automatic arbitrate(input int m, input logic [N-1:0] r);
    int w;
    logic [N-1:0] e;
    @(negedge clk);
    mode = 2'(m);
    req  = r;
    w = model_pick(m, r);
    e = N'(1) << w;
    @(negedge clk);
    check(gnt == e, $sformatf("%s/R5/R10 mode=%0d req=%0h", pol_tag(m), m, r), gnt, e);
    check((gnt & r) != '0 && $onehot(gnt), "R1", gnt, e);
    model_update(w);
    @(negedge clk);
    check(gnt == e && busy, "R3 hold", gnt, e);
    req = r & ~e;
    @(negedge clk);
    check(gnt == '0 && !busy, "R4 release", gnt, 0);
    req = '0;
    @(negedge clk);
    check(gnt == '0, "R9 idle", gnt, 0);
  endtask

  initial begin : main
    logic [N-1:0] e;
    int w;
    m_ptr = 0;
    for (int k = 0; k < N; k++) m_order[k] = k;
    m_lfsr = 8'hA5;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check(gnt == '0 && !busy, "R2 reset", gnt, 0);
    rst = 1'b0;
    @(negedge clk);
    check(gnt == '0 && !busy, "R2 after reset", gnt, 0);

    // first rotating grant with all requesting goes to processor 0
    arbitrate(0, 4'hF);
    check(m_ptr == 1, "R2 ptr", m_ptr, 1);

    // long idle stretch: nothing granted, state unchanged
    req = '0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check(gnt == '0 && !busy, "R9 long idle", gnt, 0);
    end

    // sweep all modes and request patterns
    for (int m = 0; m < 4; m++)
      for (int r = 1; r < 16; r++) arbitrate(m, 4'(r));

    // extra random and LRU passes
    for (int pass = 0; pass < 3; pass++)
      for (int r = 1; r < 16; r++) begin
        arbitrate(2, 4'(r));
        arbitrate(1, 4'(16 - r));
      end

    // handover gap with other requesters still waiting (R4)
    @(negedge clk);
    mode = 2'd0;
    req = 4'b0110;
    w = model_pick(0, 4'b0110);
    e = N'(1) << w;
    @(negedge clk);
    check(gnt == e, "R6 gap first grant", gnt, e);
    model_update(w);
    req = 4'b0110 & ~e;
    @(negedge clk);
    check(gnt == '0 && !busy, "R4 gap cycle", gnt, 0);
    w = model_pick(0, 4'b0110 & ~e);
    e = N'(1) << w;
    @(negedge clk);
    check(gnt == e && busy, "R4 next master", gnt, e);
    model_update(w);
    req = '0;
    @(negedge clk);
    check(gnt == '0, "R4 final release", gnt, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=0x0 expected=0x1");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule